// File: doc/BRIEF.md
# Bidirectional Inter-Processor Mailbox

The block links a host processor and a remote processor through two independent one-way word queues. Messages travelling from host to remote go through the outbound queue. Replies travelling back go through the inbound queue. Each queue holds eight 32-bit words. The block passes words through unchanged. A typical word carries a channel number in its low four bits, ORed with a 16-byte-aligned value in the upper 28 bits.

The host reaches the block over a simple register bus with address, write strobe, read strobe, write data and read data. Read data is combinational and is valid while the read strobe is high. The register map is split by direction:

- A write to offset 0x20 pushes an outbound word.
- A read of offset 0x00 returns the oldest inbound word and pops it in the same cycle.
- The status word of the outbound queue sits at offset 0x38.
- The status word of the inbound queue sits at offset 0x18.
- In each status word, bit 31 is the full flag and bit 30 is the empty flag.
- Bit 0 of the outbound status word is a sticky overflow flag.

The remote side uses two valid/ready handshakes. One drains the outbound queue and the other fills the inbound queue.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous active-high reset, both queues are empty. A read of either status word (0x18, 0x38) returns 0x40000000, meaning empty set, full clear and overflow clear. `rem_out_valid` is 0 and `rem_in_ready` is 1.
- R2: A host write to offset 0x20 pushes the write data, unchanged, into the outbound queue. The remote side sees the words in push order on `rem_out_data` while `rem_out_valid` is 1. A word is removed in each cycle that both `rem_out_valid` and `rem_out_ready` are 1.
- R3: After eight unread outbound pushes, bit 31 of the 0x38 status word is 1 and bit 30 is 0. Bit 30 returns to 1 once the remote side has drained every word.
- R4: A host write to 0x20 while the outbound queue is full is dropped and sets bit 0 of the 0x38 status word. That bit stays set until the host writes 0x38 with data bit 0 equal to 1. Writing 0x38 with data bit 0 equal to 0 leaves it set.
- R5: While `rem_in_ready` is 1, a remote word offered with `rem_in_valid` is pushed into the inbound queue. A host read of 0x00 returns the oldest inbound word and removes it, so that successive reads return the words in push order.
- R6: After eight unread inbound pushes, the 0x18 status word reads 0x80000000 and `rem_in_ready` is 0. A word offered while the queue is full is not stored.
- R7: A host read of 0x00 while the inbound queue is empty returns zero, and the inbound status remains empty.
- R8: Host writes to offsets 0x00 and 0x18 are ignored. At 0x38, every bit other than the overflow-clear bit is ignored. A read of any offset other than 0x00, 0x18 and 0x38, including 0x20, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 6 | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (a read of 0x00 pops) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational, zero when no read |
| rem_out_valid | output | 1 | Outbound word available to remote |
| rem_out_ready | input | 1 | Remote accepts the outbound word |
| rem_out_data | output | 32 | Oldest outbound word |
| rem_in_valid | input | 1 | Remote offers an inbound word |
| rem_in_ready | output | 1 | Inbound queue has space |
| rem_in_data | input | 32 | Inbound word from remote |

## Verification
The outbound overflow path is the hardest to reach. It needs eight host pushes with the remote side holding `rem_out_ready` low throughout, and then a ninth push. The stimulus table does exactly that. It then checks the sticky bit across a write of zero and across a write of one. Afterwards the remote side drains the queue, which shows that the dropped word never entered the queue. The inbound side is filled to full in the same way, so that a refused offer and the ignored host writes can be observed before the host reads the queue empty.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 6;

  // host byte offsets
  localparam logic [OFS_W-1:0] OFS_IN_DATA  = 6'h00;
  localparam logic [OFS_W-1:0] OFS_IN_STAT  = 6'h18;
  localparam logic [OFS_W-1:0] OFS_OUT_DATA = 6'h20;
  localparam logic [OFS_W-1:0] OFS_OUT_STAT = 6'h38;

  // status word bit positions
  localparam int unsigned BIT_FULL  = 31;
  localparam int unsigned BIT_EMPTY = 30;
  localparam int unsigned BIT_OVF   = 0;

  typedef struct packed {
    logic full;
    logic empty;
  } q_flags_t;

  function automatic logic [WORD_W-1:0] pack_status(q_flags_t f, logic ovf);
    logic [WORD_W-1:0] s;
    s            = '0;
    s[BIT_FULL]  = f.full;
    s[BIT_EMPTY] = f.empty;
    s[BIT_OVF]   = ovf;
    return s;
  endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output ipc_mailbox_pkg::q_flags_t flags
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  // named internal events
  logic push_fire, pop_fire;

  function automatic logic [PTR_W-1:0] ptr_step(logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign flags.full  = (count == CNT_MAX);
  assign flags.empty = (count == '0);
  assign push_fire   = push && !flags.full;
  assign pop_fire    = pop && !flags.empty;
  assign pop_data    = flags.empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_fire) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= ptr_step(wr_ptr);
      end
      if (pop_fire) rd_ptr <= ptr_step(rd_ptr);
      case ({push_fire, pop_fire})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assert_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_MAX);

  assert_fill_sets_full_R3: assert property (@(posedge clk) disable iff (rst)
    (push_fire && !pop_fire && count == CNT_MAX - CNT_W'(1)) |=> flags.full);

  assert_full_refuses_R6: assert property (@(posedge clk) disable iff (rst)
    (flags.full && push && !pop) |=> (flags.full && $stable(wr_ptr)));

  assert_empty_pop_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (flags.empty && pop && !push) |=> (flags.empty && $stable(rd_ptr)));
endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
  import ipc_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              clr_bit,
  output logic [WORD_W-1:0] host_rdata,
  input  q_flags_t          in_flags,
  input  logic [WORD_W-1:0] in_head,
  output logic              in_pop_req,
  input  q_flags_t          out_flags,
  output logic              out_push_req
);
  logic ovf;
  logic ovf_set, ovf_clr;

  assign out_push_req = host_wr && (host_addr == OFS_OUT_DATA);
  assign in_pop_req   = host_rd && (host_addr == OFS_IN_DATA);
  assign ovf_set      = out_push_req && out_flags.full;
  assign ovf_clr      = host_wr && (host_addr == OFS_OUT_STAT) && clr_bit;

  always_ff @(posedge clk) begin
    if (rst)          ovf <= 1'b0;
    else if (ovf_set) ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      case (host_addr)
        OFS_IN_DATA:  host_rdata = in_head;
        OFS_IN_STAT:  host_rdata = pack_status(in_flags, 1'b0);
        OFS_OUT_STAT: host_rdata = pack_status(out_flags, ovf);
        default:      host_rdata = '0;
      endcase
    end
  end

  assert_drop_sets_ovf_R4: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == OFS_OUT_DATA && out_flags.full) |=> ovf);

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == OFS_IN_DATA && in_flags.empty) |-> host_rdata == '0);

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr != OFS_IN_DATA && host_addr != OFS_IN_STAT &&
     host_addr != OFS_OUT_STAT) |-> host_rdata == '0);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              rem_out_valid,
  input  logic              rem_out_ready,
  output logic [WORD_W-1:0] rem_out_data,
  input  logic              rem_in_valid,
  output logic              rem_in_ready,
  input  logic [WORD_W-1:0] rem_in_data
);
  q_flags_t          out_flags, in_flags;
  logic [WORD_W-1:0] in_head;
  logic              out_push_req, in_pop_req;

  mbx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_out_q (
    .clk       (clk),
    .rst       (rst),
    .push      (out_push_req),
    .push_data (host_wdata),
    .pop       (rem_out_ready),
    .pop_data  (rem_out_data),
    .flags     (out_flags)
  );

  mbx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_in_q (
    .clk       (clk),
    .rst       (rst),
    .push      (rem_in_valid),
    .push_data (rem_in_data),
    .pop       (in_pop_req),
    .pop_data  (in_head),
    .flags     (in_flags)
  );

  mbx_host_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .clr_bit      (host_wdata[BIT_OVF]),
    .host_rdata   (host_rdata),
    .in_flags     (in_flags),
    .in_head      (in_head),
    .in_pop_req   (in_pop_req),
    .out_flags    (out_flags),
    .out_push_req (out_push_req)
  );

  assign rem_out_valid = !out_flags.empty;
  assign rem_in_ready  = !in_flags.full;

  assert_remote_sees_word_R2: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == OFS_OUT_DATA && !rem_out_valid) |=> rem_out_valid);

  assert_host_sees_word_R5: assert property (@(posedge clk) disable iff (rst)
    (rem_in_valid && rem_in_ready && !(host_rd && host_addr == OFS_IN_DATA))
      |=> !in_flags.empty);
endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  host_addr;
  logic        host_wr, host_rd;
  logic [31:0] host_wdata, host_rdata;
  logic        rem_out_valid, rem_out_ready;
  logic [31:0] rem_out_data;
  logic        rem_in_valid, rem_in_ready;
  logic [31:0] rem_in_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ipc_mailbox i_ipc_mailbox (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rem_out_valid(rem_out_valid), .rem_out_ready(rem_out_ready),
    .rem_out_data(rem_out_data),
    .rem_in_valid(rem_in_valid), .rem_in_ready(rem_in_ready),
    .rem_in_data(rem_in_data)
  );

  // expected status words: full = bit31, empty = bit30, overflow = bit0
  localparam logic [31:0] ST_EMPTY = 32'h4000_0000;
  localparam logic [31:0] ST_FULL  = 32'h8000_0000;
  localparam logic [31:0] ST_MID   = 32'h0000_0000;

  // {req[74:71], is_read[70], addr[69:64], data[63:32], expected[31:0]}
  localparam int NVEC = 16;
  localparam logic [74:0] VEC [NVEC] = '{
    {4'd2, 1'b0, 6'h20, 32'h0010_0008, 32'h0},   // R2 fill outbound
    {4'd2, 1'b0, 6'h20, 32'h0010_0018, 32'h0},
    {4'd2, 1'b0, 6'h20, 32'h0010_0028, 32'h0},
    {4'd3, 1'b1, 6'h38, 32'h0,         ST_MID},  // R3 partly filled
    {4'd2, 1'b0, 6'h20, 32'h0010_0038, 32'h0},
    {4'd2, 1'b0, 6'h20, 32'h0010_0048, 32'h0},
    {4'd2, 1'b0, 6'h20, 32'h0010_0058, 32'h0},
    {4'd2, 1'b0, 6'h20, 32'h0010_0068, 32'h0},
    {4'd2, 1'b0, 6'h20, 32'h0010_0078, 32'h0},
    {4'd3, 1'b1, 6'h38, 32'h0,         ST_FULL},              // R3 full after eight
    {4'd4, 1'b0, 6'h20, 32'hDEAD_0008, 32'h0},                // R4 dropped push
    {4'd4, 1'b1, 6'h38, 32'h0,         ST_FULL | 32'h1},      // R4 overflow set
    {4'd4, 1'b0, 6'h38, 32'h0,         32'h0},                // R4 write 0: keeps
    {4'd4, 1'b1, 6'h38, 32'h0,         ST_FULL | 32'h1},
    {4'd4, 1'b0, 6'h38, 32'h1,         32'h0},                // R4 write 1: clears
    {4'd4, 1'b1, 6'h38, 32'h0,         ST_FULL}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
    rem_out_ready = 1'b0; rem_in_valid = 1'b0; rem_in_data = '0;
  endtask

  task automatic host_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic host_read(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic remote_take(output logic v, output logic [31:0] d);
    @(negedge clk);
    rem_out_ready = 1'b1;
    #1 v = rem_out_valid; d = rem_out_data;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic remote_give(logic [31:0] d, output logic rdy);
    @(negedge clk);
    rem_in_valid = 1'b1; rem_in_data = d;
    #1 rdy = rem_in_ready;
    @(posedge clk); #1;
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    host_read(6'h18, d); check("R1 in status", d, ST_EMPTY);
    host_read(6'h38, d); check("R1 out status", d, ST_EMPTY);
    #1 check("R1 out valid", {31'b0, rem_out_valid}, 32'h0);
    check("R1 in ready", {31'b0, rem_in_ready}, 32'h1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][70]) begin
        host_read(VEC[i][69:64], d);
        check($sformatf("R%0d vec %0d", VEC[i][74:71], i), d, VEC[i][31:0]);
      end else begin
        host_write(VEC[i][69:64], VEC[i][63:32]);
      end
    end

    // R2 remote drains in order; dropped word (R4) never appears
    for (int i = 0; i < 8; i++) begin
      remote_take(v, d);
      check("R2 out valid", {31'b0, v}, 32'h1);
      check("R2 out order", d, 32'h0010_0008 + 32'(i * 16));
    end
    #1 check("R4 dropped word absent", {31'b0, rem_out_valid}, 32'h0);
    host_read(6'h38, d); check("R3 drained empty", d, ST_EMPTY);

    // R5/R6 fill inbound from remote
    for (int i = 0; i < 8; i++) begin
      remote_give(32'hA000_0003 + 32'(i * 16), v);
      check("R5 in ready", {31'b0, v}, 32'h1);
    end
    #1 check("R6 ready low when full", {31'b0, rem_in_ready}, 32'h0);
    remote_give(32'hBAD0_0001, v);
    host_read(6'h18, d); check("R6 in status full", d, ST_FULL);

    // R8 ignored writes and unmapped reads
    host_write(6'h00, 32'hFFFF_FFFF);
    host_write(6'h18, 32'hFFFF_FFFF);
    host_write(6'h38, 32'hFFFF_FFFE);
    host_read(6'h38, d); check("R8 out status unchanged", d, ST_EMPTY);
    host_read(6'h18, d); check("R8 in status unchanged", d, ST_FULL);
    #1 check("R8 no outbound push", {31'b0, rem_out_valid}, 32'h0);
    host_read(6'h04, d); check("R8 unmapped 04", d, 32'h0);
    host_read(6'h20, d); check("R8 unmapped 20", d, 32'h0);
    host_read(6'h3C, d); check("R8 unmapped 3C", d, 32'h0);

    // R5 host pops in order; refused word (R6) absent
    for (int i = 0; i < 8; i++) begin
      host_read(6'h00, d);
      check("R5 in order", d, 32'hA000_0003 + 32'(i * 16));
    end
    host_read(6'h18, d); check("R6 refused word absent", d, ST_EMPTY);

    // R7 empty read
    host_read(6'h00, d); check("R7 empty read zero", d, 32'h0);
    host_read(6'h18, d); check("R7 still empty", d, ST_EMPTY);

    // R1 reset clears a populated mailbox with overflow set
    for (int i = 0; i < 9; i++) host_write(6'h20, 32'h0020_0008);
    for (int i = 0; i < 3; i++) remote_give(32'h0030_0005, v);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    host_read(6'h38, d); check("R1 reset out", d, ST_EMPTY);
    host_read(6'h18, d); check("R1 reset in", d, ST_EMPTY);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule